// File: doc/BRIEF.md
# Static Memory Read Sequencer

This block runs read cycles on up to four static memory banks: ROM, flash or SRAM, one active-low chip select per bank. A request gives a bank number and a byte address, and the block answers with one or more 32-bit words. Each word is flagged by a one-cycle done strobe. Each bank has its own 16-bit timing field. The field sets the device kind (single-word or burst ROM), the bus width (16 or 32 bits) and three delays: the first-access wait, the wait for later burst beats, and a recovery gap after the chip select is released. Two 32-bit software-visible registers hold the four fields. Bank n lives in register n/2, in the low half when n is even and the high half when n is odd.

All timing is counted in memory clocks, and a memory clock lasts two core clocks. The block makes a memory-clock enable from the core clock and moves its state only on that enable. On a 16-bit bank each 32-bit word takes two half-word reads at consecutive addresses, and the low half comes first. Bank 0 leaves reset set to the slowest timing. Its width is taken from a boot-select pin, so the first code fetch works before software has touched the registers.

The control state machine has four states:
- `ST_IDLE` takes a request (valid and ready) and goes to `ST_ALIGN`.
- `ST_ALIGN` waits for the next memory-clock enable, then asserts the chip select and goes to `ST_ACCESS`.
- `ST_ACCESS` stays put while words remain. When the last unit is captured it goes to `ST_RECOV` if the recovery delay is nonzero, and to `ST_IDLE` otherwise.
- `ST_RECOV` goes to `ST_IDLE` when the recovery count runs out.

Top module: `smem_rd_ctrl`

## Requirements
- R1: After reset, bank 0's field reads as 16'hFFF8 with bit 2 set to the inverse of `boot_sel`. All chip selects and `mem_oe_n` are high and `req_ready` is high.
- R2: Writing `cfg_wdata` with `cfg_sel`=s stores bits 15:0 into bank 2s and bits 31:16 into bank 2s+1. `cfg_rdata` returns `{bank 2s+1, bank 2s}` for the current `cfg_sel`.
- R3: At most one chip select is low at any time, and only the requested bank's. `mem_oe_n` is low exactly when a chip select is low.
- R4: Field layout is bits 7:3 first-access delay F, bits 12:8 later-beat delay N, bits 15:13 recovery delay Q, bit 2 width (1 = 16-bit), bits 1:0 type. The first unit of a read waits F+2 memory clocks (2·(F+2) core cycles) from chip select assertion to capture.
- R5: On a 16-bit bank each word is two half-word reads, at byte addresses a and a+2, taken from `mem_din[15:0]`. The word is returned as {second, first}. Both halves of the first word wait F+2 memory clocks each.
- R6: Type 00 and 01 return one word, type 10 returns four words and type 11 returns eight words. The words come from byte addresses a, a+4, a+8 and so on.
- R7: Each unit after the first word waits N+1 memory clocks. This applies to each half on a 16-bit bank.
- R8: After the chip select rises, no new chip select falls for at least Q memory clocks.
- R9: `req_ready` is high only in the idle state. `rd_done` is a one-cycle pulse per returned word, and `rd_data` is valid while it is high.
- R10: The chip select stays low without interruption from the first unit to the last unit of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 1 | Boot-select pin; its inverse sets bank 0 width at reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_sel` |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_bank | input | 2 | Bank to read |
| req_addr | input | 26 | Byte start address |
| rd_done | output | 1 | One-cycle pulse per returned word |
| rd_data | output | 32 | Returned word |
| mem_cs_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 26 | Memory byte address |
| mem_din | input | 32 | Data from memory |

## Verification
The hardest case to reach from the ports is the recovery gap between two reads of the same bank. It only shows when a second request is already waiting at the moment the first one's chip select rises. The bench therefore issues the second request right after the last done strobe of the first. It then measures the core cycles between chip select release and the next assertion, once with a nonzero recovery delay and once with zero. Burst-of-eight on a 16-bit bank is the other deep case. It stresses the switch from first-access to later-beat timing between the two halves of one word, so each strobe's arrival time is compared with a value computed from the field.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int FIELD_W = 16;
    localparam int REG_W   = 32;
    localparam int WAIT_W  = 6;

    typedef struct packed {
        logic [2:0] rrr;
        logic [4:0] rdn;
        logic [4:0] rdf;
        logic       wide16;
        logic [1:0] mtype;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_RECOV  = 2'd3
    } state_t;

    function automatic logic [3:0] beats_of(input logic [1:0] t);
        case (t)
            2'b10:   return 4'd4;
            2'b11:   return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [WAIT_W-1:0] first_wait(input bank_cfg_t c);
        return WAIT_W'(c.rdf) + WAIT_W'(2);
    endfunction

    function automatic logic [WAIT_W-1:0] next_wait(input bank_cfg_t c);
        return WAIT_W'(c.rdn) + WAIT_W'(1);
    endfunction

endpackage

// File: rtl/smem_clk_div.sv
module smem_clk_div #(
    parameter int DIV = 2,
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic mem_ce
);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph     <= '0;
            mem_ce <= 1'b0;
        end else begin
            ph     <= (ph == PH_W'(DIV - 1)) ? '0 : ph + PH_W'(1);
            mem_ce <= (ph == PH_W'(DIV - 1));
        end
    end

endmodule

// File: rtl/smem_wait_cnt.sv
module smem_wait_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    input  logic         tick,
    output logic         last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (tick && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));

endmodule

// File: rtl/smem_cfg_regs.sv
module smem_cfg_regs
    import smem_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int NREG  = NBANK / 2,
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     boot_sel,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    output logic [NBANK*FIELD_W-1:0] fields
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [SEL_W-1:0] MY_REG = SEL_W'(g / 2);
        logic               hit;
        logic [FIELD_W-1:0] wsrc;
        logic [FIELD_W-1:0] fld_q;

        assign hit  = we && (sel == MY_REG);
        assign wsrc = (g % 2 == 1) ? wdata[REG_W-1:FIELD_W] : wdata[FIELD_W-1:0];

        if (g == 0) begin : g_boot
            // slowest timing, width from the boot pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    fld_q <= {{(FIELD_W-3){1'b1}}, ~boot_sel, 2'b00};
                else if (hit)
                    fld_q <= wsrc;
            end
        end else begin : g_plain
            // no reset: contents undefined until software writes them
            always_ff @(posedge clk) begin
                if (hit)
                    fld_q <= wsrc;
            end
        end

        assign fields[g*FIELD_W +: FIELD_W] = fld_q;
    end

    always_comb begin
        rdata = fields[sel*REG_W +: REG_W];
    end

endmodule

// File: rtl/smem_rd_ctrl.sv
module smem_rd_ctrl
    import smem_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int NBANK  = 4,
    localparam int BANK_W = $clog2(NBANK),
    localparam int NREG   = NBANK / 2,
    localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_sel,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rd_done,
    output logic [31:0]       rd_data,
    output logic [NBANK-1:0]  mem_cs_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_din
);

    logic                     mem_ce;
    logic [NBANK*FIELD_W-1:0] cfg_flat;
    bank_cfg_t                req_cfg;
    bank_cfg_t                cfg_q;
    logic [2:0]               act_rrr;

    state_t                   state, state_nx;
    logic [BANK_W-1:0]        bank_q;
    logic [ADDR_W-1:0]        base_q;
    logic [2:0]               beat_q;
    logic                     half_q;
    logic [15:0]              lo_q;

    logic                     cnt_load;
    logic [WAIT_W-1:0]        cnt_val;
    logic                     cnt_last;
    logic                     unit_done;
    logic                     last_unit;
    logic                     next_is_first;

    smem_clk_div #(.DIV(2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .mem_ce (mem_ce)
    );

    smem_cfg_regs #(.NBANK(NBANK)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_sel (boot_sel),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .fields   (cfg_flat)
    );

    smem_wait_cnt #(.W(WAIT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .value (cnt_val),
        .tick  (mem_ce),
        .last  (cnt_last)
    );

    assign req_cfg       = bank_cfg_t'(cfg_flat[req_bank*FIELD_W +: FIELD_W]);
    assign act_rrr       = cfg_q.rrr;
    assign unit_done     = (state == ST_ACCESS) && mem_ce && cnt_last;
    assign last_unit     = (!cfg_q.wide16 || half_q) &&
                           ({1'b0, beat_q} == beats_of(cfg_q.mtype) - 4'd1);
    // second half of the first word still uses the first-access delay
    assign next_is_first = cfg_q.wide16 && !half_q && (beat_q == 3'd0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and wait counter control
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid)
                    state_nx = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (mem_ce) begin
                    state_nx = ST_ACCESS;
                    cnt_load = 1'b1;
                    cnt_val  = first_wait(cfg_q);
                end
            end
            ST_ACCESS: begin
                if (unit_done) begin
                    if (last_unit) begin
                        cnt_val = WAIT_W'(act_rrr);
                        if (act_rrr == 3'd0) begin
                            state_nx = ST_IDLE;
                        end else begin
                            state_nx = ST_RECOV;
                            cnt_load = 1'b1;
                        end
                    end else begin
                        cnt_load = 1'b1;
                        cnt_val  = next_is_first ? first_wait(cfg_q) : next_wait(cfg_q);
                    end
                end
            end
            ST_RECOV: begin
                if (mem_ce && cnt_last)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture and data assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= '0;
            base_q  <= '0;
            beat_q  <= '0;
            half_q  <= 1'b0;
            lo_q    <= '0;
            cfg_q   <= '0;
            rd_data <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            if (state == ST_IDLE && req_valid) begin
                bank_q <= req_bank;
                base_q <= req_addr;
                beat_q <= '0;
                half_q <= 1'b0;
                cfg_q  <= req_cfg;
            end
            if (unit_done) begin
                if (cfg_q.wide16 && !half_q) begin
                    lo_q   <= mem_din[15:0];
                    half_q <= 1'b1;
                end else begin
                    rd_data <= cfg_q.wide16 ? {mem_din[15:0], lo_q} : mem_din;
                    rd_done <= 1'b1;
                    half_q  <= 1'b0;
                    beat_q  <= beat_q + 3'd1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_cs_n  = '1;
        mem_oe_n  = 1'b1;
        if (state == ST_ACCESS) begin
            mem_cs_n[bank_q] = 1'b0;
            mem_oe_n         = 1'b0;
        end
        mem_addr = base_q + ADDR_W'({beat_q, half_q, 1'b0});
    end

endmodule

// File: rtl/smem_rd_ctrl_chk.sv
module smem_rd_ctrl_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] cs_n,
    input logic             oe_n,
    input logic             req_ready,
    input logic             done,
    input logic [2:0]       act_rrr
);

    logic [7:0] gap;
    logic [2:0] rrr_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap   <= 8'hFF;
            rrr_l <= 3'd0;
        end else if (&cs_n) begin
            gap <= (gap == 8'hFF) ? gap : gap + 8'd1;
        end else begin
            gap   <= 8'd0;
            rrr_l <= act_rrr;
        end
    end

    p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    p_oe_with_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n == (&cs_n));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |-> !req_ready);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |=> ((&cs_n) || $stable(cs_n)));

    p_recov_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&cs_n) |-> (gap >= ({4'b0, rrr_l, 1'b0} + 8'd1)));

endmodule

bind smem_rd_ctrl smem_rd_ctrl_chk #(.NBANK(NBANK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .req_ready (req_ready),
    .done      (rd_done),
    .act_rrr   (act_rrr)
);

// File: tb/tb_smem_rd_ctrl.sv
`timescale 1ns/1ps
module tb_smem_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boot_sel;
    logic        cfg_we;
    logic [0:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_bank;
    logic [25:0] req_addr;
    logic        rd_done;
    logic [31:0] rd_data;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n;
    logic [25:0] mem_addr;
    logic [31:0] mem_din;

    always #2.5 clk = ~clk;

    smem_rd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_addr(req_addr),
        .rd_done(rd_done), .rd_data(rd_data),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_din(mem_din)
    );

    function automatic logic [31:0] pat(input logic [25:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h1357};
    endfunction

    assign mem_din = pat(mem_addr);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_end = 0;
    int last_gap = 0;
    logic [15:0] shadow [4];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fld(input int q, input int n, input int f, input int w, input int t);
        return {3'(q), 5'(n), 5'(f), 1'(w), 2'(t)};
    endfunction

    task automatic write_reg(input int r);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 1'(r);
        cfg_wdata = {shadow[2*r+1], shadow[2*r]};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset(input logic bs);
        boot_sel = bs;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one read; checks data, strobe timing, word count and chip select exclusivity
    task automatic do_read(input int b, input logic [25:0] a);
        logic [15:0] f;
        logic [31:0] lo_w, hi_w, expd;
        logic [25:0] wa;
        int w, n, k, d1, dn, t, words, bad, expt;
        f  = shadow[b];
        w  = int'(f[2]);
        n  = (f[1:0] == 2'b10) ? 4 : (f[1:0] == 2'b11) ? 8 : 1;
        k  = w ? 2 : 1;
        d1 = int'(f[7:3]) + 2;
        dn = int'(f[12:8]) + 1;
        t = 0; words = 0; bad = 0;
        @(negedge clk);
        req_bank  = 2'(b);
        req_addr  = a;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (mem_cs_n[b]) @(negedge clk);
        last_gap = cyc - last_end;
        forever begin
            @(negedge clk);
            t++;
            if (!mem_cs_n[b] && (mem_cs_n != ~(4'b0001 << b) || mem_oe_n || req_ready))
                bad++;
            if (rd_done) begin
                wa   = a + 26'(4 * words);
                lo_w = pat(wa);
                hi_w = pat(wa + 26'd2);
                expd = w ? {hi_w[15:0], lo_w[15:0]} : lo_w;
                expt = k * 2 * d1 + words * k * 2 * dn;
                chk(rd_data == expd, w ? "R5 half-word assembly" : "R6 word data", rd_data, expd);
                chk(t == expt, (words == 0) ? "R4 first access timing" : "R7 later beat timing",
                    32'(t), 32'(expt));
                words++;
            end
            if (mem_cs_n[b]) break;
        end
        last_end = cyc;
        chk(words == n, "R6 R9 words per request", 32'(words), 32'(n));
        chk(bad == 0, "R3 R10 single select held", 32'(bad), 32'd0);
    endtask

    task automatic sc_reset_state();
        cfg_sel = 1'b0;
        #1;
        chk(cfg_rdata[15:0] == 16'hFFFC, "R1 bank0 reset field boot=0", 32'(cfg_rdata[15:0]), 32'hFFFC);
        chk(mem_cs_n == 4'hF && mem_oe_n, "R1 selects idle", {27'd0, mem_oe_n, mem_cs_n}, 32'h1F);
        chk(req_ready, "R1 R9 ready after reset", 32'(req_ready), 32'd1);
    endtask

    task automatic sc_boot_default();
        shadow[0] = 16'hFFFC;
        do_read(0, 26'h100);
    endtask

    task automatic sc_cfg_layout();
        shadow[0] = fld(0, 0, 4, 0, 0);
        shadow[1] = fld(0, 1, 3, 0, 1);
        shadow[2] = fld(5, 0, 1, 1, 0);
        shadow[3] = fld(2, 1, 2, 0, 2);
        write_reg(0);
        write_reg(1);
        cfg_sel = 1'b1;
        #1;
        chk(cfg_rdata == {shadow[3], shadow[2]}, "R2 register 1 halves", cfg_rdata, {shadow[3], shadow[2]});
        cfg_sel = 1'b0;
        #1;
        chk(cfg_rdata == {shadow[1], shadow[0]}, "R2 register 0 halves", cfg_rdata, {shadow[1], shadow[0]});
    endtask

    task automatic sc_nonburst32();
        do_read(1, 26'h2000);
    endtask

    task automatic sc_half16();
        do_read(2, 26'h3000);
    endtask

    task automatic sc_burst4();
        do_read(3, 26'h0400);
    endtask

    task automatic sc_burst8_16();
        shadow[1] = fld(1, 2, 0, 1, 3);
        write_reg(0);
        do_read(1, 26'h0800);
    endtask

    task automatic sc_recovery();
        do_read(2, 26'h0040);
        do_read(2, 26'h0080);
        chk(last_gap >= 12 && last_gap <= 14, "R8 recovery gap Q=5", 32'(last_gap), 32'd12);
        do_read(0, 26'h0010);
        do_read(0, 26'h0020);
        chk(last_gap >= 2 && last_gap <= 4, "R8 no recovery Q=0", 32'(last_gap), 32'd2);
    endtask

    task automatic sc_boot_pin_high();
        do_reset(1'b1);
        cfg_sel = 1'b0;
        #1;
        chk(cfg_rdata[15:0] == 16'hFFF8, "R1 bank0 reset field boot=1", 32'(cfg_rdata[15:0]), 32'hFFF8);
        shadow[0] = 16'hFFF8;
        do_read(0, 26'h0200);
    endtask

    initial begin
        rst_n = 1'b0; boot_sel = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_bank = '0; req_addr = '0;
        do_reset(1'b0);
        sc_reset_state();
        sc_boot_default();
        sc_cfg_layout();
        sc_nonburst32();
        sc_half16();
        sc_burst4();
        sc_burst8_16();
        sc_recovery();
        sc_boot_pin_high();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule